// File: doc/BRIEF.md
# RTC Compare/Capture Event Flag Unit

This block turns a free-running real-time counter into three sticky channel flags. The counter is 32 bits wide and runs in the slow clock domain: the upper 16 bits count whole seconds and the lower 16 bits count fractions of a second. Each channel compares the counter with its own compare value. It raises its flag when the counter has reached that value or has gone past it by less than one second. Because the test is a look-back window and not an equality, a compare value written a little too late still produces its event. A compare value written up to one second in the past fires on the next slow clock edge.

Channel 1 can be switched into capture mode. In that mode a rising edge on the capture strobe sets its flag and stores the counter value, and the channel 1 compare result is no longer used. Software clears a flag by writing 1 to it through a per-channel clear strobe. After a clear, the channel ignores new events for two slow-clock cycles. Each flag also drives a one-cycle event pulse when it goes from 0 to 1. The counter itself and the bus decoder are outside this block. The bus decoder maps the status bits of a write onto the clear strobes.

Top module: `rtc_evflag_unit`

## Requirements
- R1: After reset the status word reads zero. Channel flags appear at bit 0 (channel 0), bit 8 (channel 1) and bit 16 (channel 2), and every other status bit reads 0.
- R2: A channel's flag is never set while that channel's enable is 0.
- R3: In compare mode an enabled channel sets its flag at the next clock edge when the unsigned 32-bit difference (counter − compare) is between 0 and 0xFFFF. The difference wraps modulo 2^32. It stays clear when the difference is 0x10000 or more, including when the compare value lies ahead of the counter.
- R4: If an enabled channel's compare value is changed to a value at most one second behind the counter, the flag is set at the very next edge. If the value is changed to counter+1, the flag is set on the edge after the counter reaches that value.
- R5: When the capture-mode select is 1, the channel 1 flag is set only by a rising edge of the capture strobe while channel 1 is enabled. A compare match on channel 1 is then ignored.
- R6: A clear strobe of 1 for a channel clears that channel's flag at the next edge. A strobe of 0 leaves the flag unchanged, and the other channels are not affected.
- R7: A clear wins over an event in the same cycle. After a clear, the flag stays 0 at the clear edge and at the two edges that follow, even if the set condition holds throughout. It can be set again at the third edge after the clear.
- R8: A set flag stays set until it is cleared, even after its set condition goes away.
- R9: In capture mode with channel 1 enabled, a rising strobe edge stores the counter value into the capture output at the same edge that sets the flag. A strobe held high captures nothing further.
- R10: A channel's event output is high for exactly the one cycle in which its flag changes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock that also advances the counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 32 | Counter value: 16 bits of seconds, 16 bits of fraction |
| ch_en_i | input | 3 | Enable for each channel |
| cap_mode_i | input | 1 | Channel 1 source select: 1 = capture, 0 = compare |
| cap_strobe_i | input | 1 | Capture strobe; its rising edge is the capture event |
| cmp_i | input | 96 | Compare values; channel c occupies bits [32c+31:32c] |
| flag_clr_i | input | 3 | Write-one-to-clear strobes, one per channel |
| flag_o | output | 32 | Status word holding the channel flags at bits 0, 8 and 16 |
| event_o | output | 3 | One-cycle pulse per channel when its flag is set |
| cap_val_o | output | 32 | Counter value stored at the last channel 1 capture |

## Verification
A blanking counter that is stuck or off by one shows up within three edges of a clear. This happens when the set condition is held true: the flag comes back at the wrong edge or never comes back. An error in the window comparison shows up at the very next edge as a wrong flag bit. The bench probes differences of 0xFFFF and 0x10000, values just ahead of the counter, and wrapped values to expose it. A broken edge detector or capture latch shows up as a wrong or missing capture value when the strobe is held high or pulsed again. An event register that is not tied to the flag's 0-to-1 change shows up as a pulse that lasts too long or comes on the wrong edge.

// File: rtl/rtc_evf_pkg.sv
package rtc_evf_pkg;
  parameter int unsigned FLAG_STRIDE = 8;

  typedef enum logic {
    SRC_COMPARE = 1'b0,
    SRC_CAPTURE = 1'b1
  } ch_src_e;

  function automatic int unsigned flag_pos(input int unsigned ch);
    return ch * FLAG_STRIDE;
  endfunction
endpackage

// File: rtl/rtc_evf_window.sv
module rtc_evf_window #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned WIN_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o
);
  localparam int unsigned HI_W = CNT_W - WIN_W;

  logic [CNT_W-1:0] diff;

  // reached or passed by less than one window (modulo wrap)
  always_comb begin
    diff  = cnt_i - cmp_i;
    hit_o = (diff[CNT_W-1:WIN_W] == HI_W'(0));
  end
endmodule

// File: rtl/rtc_evf_capture.sv
module rtc_evf_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             arm_i,
  input  logic             strobe_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] cap_o
);
  logic             strobe_q;
  logic [CNT_W-1:0] cap_q;

  assign edge_o = arm_i & strobe_i & ~strobe_q;
  assign cap_o  = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      cap_q    <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (edge_o) cap_q <= cnt_i;
    end
  end

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strobe_i) && arm_i) |=> (cap_o == $past(cnt_i))); // R9
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && $past(strobe_i)) |=> $stable(cap_o)); // R9
endmodule

// File: rtl/rtc_evf_chan.sv
module rtc_evf_chan #(
  parameter int unsigned BLANK_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o,
  output logic event_o
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] blank_q;
  logic          flag_q;
  logic          event_q;
  logic          set;

  assign set     = en_i & hit_i & (blank_q == BW'(0)) & ~clr_i;
  assign flag_o  = flag_q;
  assign event_o = event_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '0;
      flag_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= set & ~flag_q;
      if (clr_i) begin
        flag_q  <= 1'b0;
        blank_q <= BW'(BLANK_CYC);
      end else begin
        if (blank_q != BW'(0)) blank_q <= blank_q - BW'(1);
        if (set) flag_q <= 1'b1;
      end
    end
  end

  AST_NEED_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q); // R2
  AST_CLR_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q ##1 !flag_q ##1 !flag_q); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R8
  AST_EVENT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> (flag_q && !$past(flag_q))); // R10
  AST_EVENT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |=> !event_q); // R10
endmodule

// File: rtl/rtc_evflag_unit.sv
module rtc_evflag_unit
  import rtc_evf_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned WIN_W     = 16,
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned CAP_CH    = 1,
  parameter int unsigned BLANK_CYC = 2,
  parameter int unsigned STAT_W    = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic                    cap_mode_i,
  input  logic                    cap_strobe_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_i,
  input  logic [NUM_CH-1:0]       flag_clr_i,
  output logic [STAT_W-1:0]       flag_o,
  output logic [NUM_CH-1:0]       event_o,
  output logic [CNT_W-1:0]        cap_val_o
);
  localparam int unsigned TOP_BIT = (NUM_CH - 1) * FLAG_STRIDE;

  logic [NUM_CH-1:0] flag;
  logic              cap_edge;
  ch_src_e           cap_src;

  assign cap_src = cap_mode_i ? SRC_CAPTURE : SRC_COMPARE;

  rtc_evf_capture #(.CNT_W(CNT_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .arm_i   (ch_en_i[CAP_CH] & (cap_src == SRC_CAPTURE)),
    .strobe_i(cap_strobe_i),
    .edge_o  (cap_edge),
    .cap_o   (cap_val_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cmp_hit;
    logic hit;

    rtc_evf_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_window (
      .cnt_i(cnt_i),
      .cmp_i(cmp_i[g*CNT_W +: CNT_W]),
      .hit_o(cmp_hit)
    );

    if (g == CAP_CH) begin : g_cap
      assign hit = (cap_src == SRC_CAPTURE) ? cap_edge : cmp_hit;
    end else begin : g_cmp
      assign hit = cmp_hit;
    end

    rtc_evf_chan #(.BLANK_CYC(BLANK_CYC)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en_i[g]),
      .hit_i  (hit),
      .clr_i  (flag_clr_i[g]),
      .flag_o (flag[g]),
      .event_o(event_o[g])
    );
  end

  always_comb begin
    flag_o = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) flag_o[flag_pos(c)] = flag[c];
  end

  initial begin
    AST_LAYOUT_FITS: assert (TOP_BIT < STAT_W); // R1
  end

  AST_CAP_MODE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && !cap_edge && !flag[CAP_CH]) |=> !flag[CAP_CH]); // R5
endmodule

// File: tb/rtc_evflag_unit_tb.sv
`timescale 1ns/1ps
module rtc_evflag_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cnt_i = '0;
  logic [2:0]  ch_en_i = '0;
  logic        cap_mode_i = 1'b0;
  logic        cap_strobe_i = 1'b0;
  logic [95:0] cmp_i = '0;
  logic [2:0]  flag_clr_i = '0;
  logic [31:0] flag_o;
  logic [2:0]  event_o;
  logic [31:0] cap_val_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rtc_evflag_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .ch_en_i(ch_en_i),
    .cap_mode_i(cap_mode_i), .cap_strobe_i(cap_strobe_i), .cmp_i(cmp_i),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .event_o(event_o),
    .cap_val_o(cap_val_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fbit(input int c);
    return 32'h1 << (8 * c);
  endfunction

  task automatic clear_all();
    ch_en_i    = '0;
    flag_clr_i = 3'b111;
    tick();
    flag_clr_i = '0;
    tick();
    tick();
  endtask

  task automatic set_cmp(input int c, input logic [31:0] v);
    cmp_i[c*32 +: 32] = v;
  endtask

  initial begin
    logic [31:0] diffs [10] = '{32'h0, 32'h1, 32'h7FFF, 32'hFFFF, 32'h10000,
                                32'h10001, 32'hFFFF_FFFF, 32'hFFFF_FF00,
                                32'h8000_0000, 32'h0001_8000};
    logic [31:0] bases [2]  = '{32'h0005_0000, 32'h0000_4000};
    repeat (3) tick();
    chk("R1 reset status", flag_o, 32'h0);
    chk("R10 reset events", {29'h0, event_o}, 32'h0);
    rst_ni = 1'b1;
    tick();

    // R3 R8 R10: window sweep per channel, with wrap
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 18; k++) begin
          logic [31:0] d;
          logic hit;
          d = (k < 10) ? diffs[k] : 32'hFFFC + 32'(k - 10);
          hit = (d <= 32'hFFFF);
          clear_all();
          cnt_i = bases[b];
          set_cmp(c, bases[b] - d);
          ch_en_i = 3'b1 << c;
          tick();
          chk("R3 window flag", flag_o, hit ? fbit(c) : 32'h0);
          chk("R10 event on set", {29'h0, event_o}, hit ? (32'h1 << c) : 32'h0);
          set_cmp(c, bases[b] + 32'h0100_0000);
          tick();
          chk("R8 sticky after condition ends", flag_o, hit ? fbit(c) : 32'h0);
          chk("R10 event one cycle", {29'h0, event_o}, 32'h0);
        end
      end
    end

    // R2: no set while disabled
    clear_all();
    cnt_i = 32'h0010_0000;
    for (int c = 0; c < 3; c++) set_cmp(c, cnt_i);
    tick();
    tick();
    chk("R2 disabled channels", flag_o, 32'h0);

    // R4: late write behind counter, and write of counter+1
    clear_all();
    cnt_i = 32'h0002_0000;
    set_cmp(2, 32'h0003_0000);
    ch_en_i = 3'b100;
    tick();
    chk("R4 future compare idle", flag_o, 32'h0);
    set_cmp(2, 32'h0001_8000);
    tick();
    chk("R4 late compare fires", flag_o, fbit(2));
    clear_all();
    set_cmp(0, cnt_i + 32'h1);
    ch_en_i = 3'b001;
    tick();
    chk("R4 next value waits", flag_o, 32'h0);
    cnt_i = cnt_i + 32'h1;
    tick();
    chk("R4 next value fires", flag_o, fbit(0));

    // R1 R6: all set, selective clear, zero strobe
    clear_all();
    cnt_i = 32'h0040_0000;
    for (int c = 0; c < 3; c++) set_cmp(c, cnt_i);
    ch_en_i = 3'b111;
    tick();
    chk("R1 layout all set", flag_o, 32'h0001_0101);
    ch_en_i = '0;
    flag_clr_i = 3'b000;
    tick();
    chk("R6 zero strobe no effect", flag_o, 32'h0001_0101);
    flag_clr_i = 3'b010;
    tick();
    flag_clr_i = '0;
    chk("R6 clear channel 1 only", flag_o, 32'h0001_0001);

    // R7: clear wins and two-cycle blanking with condition held
    clear_all();
    set_cmp(0, cnt_i);
    ch_en_i = 3'b001;
    tick();
    chk("R7 precondition set", flag_o, fbit(0));
    flag_clr_i = 3'b001;
    tick();
    flag_clr_i = '0;
    chk("R7 clear wins", flag_o, 32'h0);
    tick();
    chk("R7 blank cycle 1", flag_o, 32'h0);
    tick();
    chk("R7 blank cycle 2", flag_o, 32'h0);
    tick();
    chk("R7 set after blank", flag_o, fbit(0));
    chk("R10 event after blank", {29'h0, event_o}, 32'h1);

    // R5 R9: capture mode on channel 1
    clear_all();
    cap_mode_i = 1'b1;
    cap_strobe_i = 1'b0;
    set_cmp(1, cnt_i);
    ch_en_i = 3'b010;
    tick();
    tick();
    chk("R5 compare ignored in capture", flag_o, 32'h0);
    cnt_i = 32'h1234_5678;
    cap_strobe_i = 1'b1;
    tick();
    chk("R5 strobe edge sets", flag_o, fbit(1));
    chk("R9 capture value", cap_val_o, 32'h1234_5678);
    cnt_i = 32'h2222_0000;
    tick();
    chk("R9 held strobe no capture", cap_val_o, 32'h1234_5678);
    cap_strobe_i = 1'b0;
    tick();
    cap_strobe_i = 1'b1;
    tick();
    chk("R9 second edge captures", cap_val_o, 32'h2222_0000);
    clear_all();
    cap_strobe_i = 1'b0;
    tick();
    cnt_i = 32'h3333_0000;
    cap_strobe_i = 1'b1;
    tick();
    chk("R2 capture disabled no flag", flag_o, 32'h0);
    chk("R9 capture disabled no latch", cap_val_o, 32'h2222_0000);
    cap_mode_i = 1'b0;
    cap_strobe_i = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule